// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block keeps a dynamic memory array alive by refreshing one row at a time at evenly spaced instants. Every row must be visited within the retention window. The block arbitrates the array between these refreshes and a single normal access port. A free-running interval timer raises a refresh obligation every `RETENTION_US / 2^ROW_BITS` microseconds, expressed in clock cycles. Each obligation becomes one refresh of the next row in ascending cyclic order. During a refresh the array is held for a fixed number of cycles derived from the refresh time and the clock frequency, and no normal access is granted.

An arbiter state machine with three states makes the decisions. `ST_IDLE` grants nothing. `ST_ACCESS` holds the grant for a normal access. `ST_REFRESH` occupies the array for one row refresh. The transitions are:

- IDLE→REFRESH when at least one refresh is owed. This has priority over a request.
- IDLE→ACCESS when `acc_req` is high and nothing is owed.
- ACCESS→REFRESH when `acc_req` drops while a refresh is owed.
- ACCESS→IDLE when `acc_req` drops and nothing is owed.
- REFRESH→IDLE after the last busy cycle.

An access is never cut short. A refresh that falls due during an access is recorded in a small debt counter and started as soon as the access ends. Because the interval timer never stops, deferring a refresh does not shift later due times. A refresh counter lets the surrounding logic measure how much bandwidth refresh consumes.

Top module: `refresh_scheduler`

## Requirements
- R1: After reset the row address is 0, the refresh count is 0, the interval timer is 0, and `acc_gnt`, `busy` and `ref_stb` are low. With no access traffic, the first `ref_stb` appears on clock edge TICK_CYC+1 after reset is released.
- R2: With no access traffic, `ref_stb` pulses exactly once every TICK_CYC cycles, where TICK_CYC = floor(CLK_MHZ*RETENTION_US / 2^ROW_BITS).
- R3: Each refresh holds `busy` high for exactly BUSY_CYC consecutive cycles, where BUSY_CYC = ceil(REFRESH_NS*CLK_MHZ/1000). `ref_stb` is a one-cycle pulse on the first of those cycles.
- R4: Refreshed rows follow ascending order modulo 2^ROW_BITS, starting at row 0. `ref_row` is stable while `busy` is high and advances by one as `busy` falls.
- R5: `acc_gnt` and `busy` are never high together. A request raised during a refresh is granted only in the second cycle after `busy` falls.
- R6: A refresh that falls due while `acc_gnt` is high waits. It starts on the clock edge that sees `acc_req` low, and `acc_gnt` is low in that same cycle.
- R7: When a refresh is owed in ST_IDLE and `acc_req` is high, the refresh is taken first. The grant follows in the second cycle after that refresh ends.
- R8: Due times stay on the fixed TICK_CYC grid no matter how long refreshes are deferred. Several owed refreshes run back to back with one idle cycle between them.
- R9: `ref_count` rises by exactly one on the cycle after each refresh completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Normal access request; held high for the whole access, dropped to end it |
| acc_gnt | output | 1 | Normal access owns the array |
| ref_stb | output | 1 | One-cycle pulse at the start of a row refresh |
| ref_row | output | ROW_BITS | Row being refreshed |
| busy | output | 1 | Array occupied by a refresh |
| ref_count | output | CNT_W | Number of completed refreshes |

## Verification
The bench builds the block with ROW_BITS=4, RETENTION_US=1, CLK_MHZ=200 and REFRESH_NS=20. This gives a 12-cycle refresh interval and a 4-cycle busy period. As a result, a full sweep of the 16 rows, the modulo wrap of the row address and more than twenty refreshes fit in a few hundred cycles, so every strobe time can be predicted from multiples of 12. The same short interval lets one long access span two due times. The bench uses this to drive the deferral, the priority case and the back-to-back catch-up, and then to confirm that the due-time grid returns.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_REFRESH = 2'd2
    } arb_state_t;

endpackage

// File: rtl/rs_interval_timer.sv
// Free-running interval timer: emits a one-cycle tick every TICK_CYC cycles.
module rs_interval_timer #(
    parameter int TICK_CYC = 610
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TC_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam logic [TC_W-1:0] LAST = TC_W'(TICK_CYC - 1);

    logic [TC_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);

endmodule

// File: rtl/rs_debt_counter.sv
// Counts refreshes that have fallen due but not yet started; saturates.
module rs_debt_counter #(
    parameter int PEND_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic owed
);
    localparam logic [PEND_W-1:0] MAXV = {PEND_W{1'b1}};

    logic [PEND_W-1:0] debt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debt <= '0;
        end else if (inc && !dec) begin
            if (debt != MAXV) begin
                debt <= debt + 1'b1;
            end
        end else if (dec && !inc) begin
            if (debt != '0) begin
                debt <= debt - 1'b1;
            end
        end
    end

    assign owed = (debt != '0);

endmodule

// File: rtl/rs_row_counter.sv
// Row address pointer and completed-refresh tally.
module rs_row_counter #(
    parameter int ROW_BITS = 14,
    parameter int CNT_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                advance,
    output logic [ROW_BITS-1:0] row,
    output logic [CNT_W-1:0]    total
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row   <= '0;
            total <= '0;
        end else if (advance) begin
            row   <= row + 1'b1;
            total <= total + 1'b1;
        end
    end

endmodule

// File: rtl/rs_arbiter_fsm.sv
// Arbiter between row refresh and the normal access port.
module rs_arbiter_fsm
    import refsched_pkg::*;
#(
    parameter int BUSY_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic owed,
    input  logic acc_req,
    output logic take_ref,
    output logic done_ref,
    output logic acc_gnt,
    output logic busy,
    output logic ref_stb
);
    localparam int BC_W = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(BUSY_CYC - 1);

    arb_state_t      state, nxt;
    logic [BC_W-1:0] busy_cnt;
    logic            last_busy;

    assign last_busy = (busy_cnt == BC_LAST);

    // State register and busy-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            busy_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == ST_REFRESH) begin
                busy_cnt <= busy_cnt + 1'b1;
            end else begin
                busy_cnt <= '0;
            end
        end
    end

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (owed) begin
                    nxt = ST_REFRESH;
                end else if (acc_req) begin
                    nxt = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (!acc_req) begin
                    nxt = owed ? ST_REFRESH : ST_IDLE;
                end
            end
            ST_REFRESH: begin
                if (last_busy) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        acc_gnt  = (state == ST_ACCESS);
        busy     = (state == ST_REFRESH);
        ref_stb  = (state == ST_REFRESH) && (busy_cnt == '0);
        take_ref = (nxt == ST_REFRESH) && (state != ST_REFRESH);
        done_ref = (state == ST_REFRESH) && last_busy;
    end

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler #(
    parameter int CLK_MHZ      = 200,
    parameter int RETENTION_US = 50000,
    parameter int ROW_BITS     = 14,
    parameter int REFRESH_NS   = 100,
    parameter int PEND_W       = 4,
    parameter int CNT_W        = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_req,
    output logic                acc_gnt,
    output logic                ref_stb,
    output logic [ROW_BITS-1:0] ref_row,
    output logic                busy,
    output logic [CNT_W-1:0]    ref_count
);
    localparam int ROWS     = 1 << ROW_BITS;
    localparam int TICK_CYC = (CLK_MHZ * RETENTION_US) / ROWS;
    localparam int BUSY_CYC = (REFRESH_NS * CLK_MHZ + 999) / 1000;

    logic tick, owed, take_ref, done_ref;

    rs_interval_timer #(.TICK_CYC(TICK_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rs_debt_counter #(.PEND_W(PEND_W)) u_debt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tick),
        .dec   (take_ref),
        .owed  (owed)
    );

    rs_arbiter_fsm #(.BUSY_CYC(BUSY_CYC)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .owed     (owed),
        .acc_req  (acc_req),
        .take_ref (take_ref),
        .done_ref (done_ref),
        .acc_gnt  (acc_gnt),
        .busy     (busy),
        .ref_stb  (ref_stb)
    );

    rs_row_counter #(.ROW_BITS(ROW_BITS), .CNT_W(CNT_W)) u_rows (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (done_ref),
        .row     (ref_row),
        .total   (ref_count)
    );

endmodule

// File: rtl/refresh_scheduler_chk.sv
module refresh_scheduler_chk #(
    parameter int CLK_MHZ    = 200,
    parameter int REFRESH_NS = 100,
    parameter int ROW_BITS   = 14,
    parameter int CNT_W      = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                acc_req,
    input logic                acc_gnt,
    input logic                ref_stb,
    input logic [ROW_BITS-1:0] ref_row,
    input logic                busy,
    input logic [CNT_W-1:0]    ref_count
);
    localparam int BUSY_CYC = (REFRESH_NS * CLK_MHZ + 999) / 1000;

    logic [15:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= '0;
        end else if (busy) begin
            run <= run + 1'b1;
        end else begin
            run <= '0;
        end
    end

    assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run == 16'(BUSY_CYC)));

    assert_stb_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stb |-> busy);

    assert_stb_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stb |=> !ref_stb);

    assert_row_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ref_stb) |-> $stable(ref_row));

    assert_row_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (ref_row == ROW_BITS'($past(ref_row) + 1'b1)));

    assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_gnt && busy));

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (ref_count == CNT_W'($past(ref_count) + 1'b1)));

    assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$fell(busy)) |-> $stable(ref_count));

endmodule

bind refresh_scheduler refresh_scheduler_chk #(
    .CLK_MHZ    (CLK_MHZ),
    .REFRESH_NS (REFRESH_NS),
    .ROW_BITS   (ROW_BITS),
    .CNT_W      (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_req   (acc_req),
    .acc_gnt   (acc_gnt),
    .ref_stb   (ref_stb),
    .ref_row   (ref_row),
    .busy      (busy),
    .ref_count (ref_count)
);

// File: tb/refresh_scheduler_test.sv
`timescale 1ns/1ps
module refresh_scheduler_test;
    localparam int ROW_BITS = 4;
    localparam int CNT_W    = 16;
    localparam int TICK     = 12;  // 200*1/16
    localparam int BUSYC    = 4;   // ceil(20*200/1000)

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                acc_req = 1'b0;
    logic                acc_gnt, ref_stb, busy;
    logic [ROW_BITS-1:0] ref_row;
    logic [CNT_W-1:0]    ref_count;

    int cyc = 0;
    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    refresh_scheduler #(
        .CLK_MHZ(200), .RETENTION_US(1), .ROW_BITS(ROW_BITS),
        .REFRESH_NS(20), .PEND_W(4), .CNT_W(CNT_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_gnt(acc_gnt),
        .ref_stb(ref_stb), .ref_row(ref_row), .busy(busy), .ref_count(ref_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic expect_stb(input string req, input int row);
        chk(ref_stb == 1'b1, req, int'(ref_stb), 1);
        chk(int'(ref_row) == row, req, int'(ref_row), row);
        chk(acc_gnt == 1'b0, req, int'(acc_gnt), 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ref_row == '0, "R1", int'(ref_row), 0);
        chk(ref_count == '0, "R1", int'(ref_count), 0);
        chk({acc_gnt, busy, ref_stb} == 3'b000, "R1", int'({acc_gnt, busy, ref_stb}), 0);
        rst_n = 1'b1;

        wait_cyc(TICK);
        chk(ref_stb == 1'b0, "R1", int'(ref_stb), 0);

        // R2/R4/R3/R9: free-running sweep with row wrap
        for (int n = 0; n < 20; n++) begin
            wait_cyc(TICK + 1 + TICK * n);
            expect_stb("R2_R4", n % 16);
            wait_cyc(TICK + 2 + TICK * n);
            chk(ref_stb == 1'b0 && busy == 1'b1, "R3", int'({ref_stb, busy}), 1);
            wait_cyc(TICK + BUSYC + TICK * n);
            chk(busy == 1'b1, "R3", int'(busy), 1);
            wait_cyc(TICK + 1 + BUSYC + TICK * n);
            chk(busy == 1'b0, "R3", int'(busy), 0);
            chk(int'(ref_count) == n + 1, "R9", int'(ref_count), n + 1);
        end

        // R5: request during refresh waits
        wait_cyc(253);
        expect_stb("R2", 4);
        wait_cyc(255);
        acc_req = 1'b1;
        wait_cyc(256);
        chk(acc_gnt == 1'b0 && busy == 1'b1, "R5", int'({acc_gnt, busy}), 1);
        wait_cyc(257);
        chk(acc_gnt == 1'b0 && busy == 1'b0, "R5", int'({acc_gnt, busy}), 0);
        wait_cyc(258);
        chk(acc_gnt == 1'b1, "R5", int'(acc_gnt), 1);

        // R6: refresh due at edge 264 deferred by the access
        wait_cyc(265);
        chk(acc_gnt == 1'b1 && busy == 1'b0 && ref_stb == 1'b0, "R6",
            int'({acc_gnt, busy, ref_stb}), 4);
        wait_cyc(270);
        chk(acc_gnt == 1'b1, "R6", int'(acc_gnt), 1);
        acc_req = 1'b0;
        wait_cyc(271);
        expect_stb("R6", 5);

        // R8: grid not shifted by deferral
        wait_cyc(276);
        chk(ref_stb == 1'b0, "R8", int'(ref_stb), 0);
        wait_cyc(277);
        expect_stb("R8", 6);

        // R7: owed refresh beats a simultaneous request
        wait_cyc(288);
        acc_req = 1'b1;
        wait_cyc(289);
        expect_stb("R7", 7);
        wait_cyc(293);
        chk(acc_gnt == 1'b0 && busy == 1'b0, "R7", int'({acc_gnt, busy}), 0);
        wait_cyc(294);
        chk(acc_gnt == 1'b1, "R7", int'(acc_gnt), 1);

        // R8: two owed refreshes run back to back
        wait_cyc(315);
        acc_req = 1'b0;
        wait_cyc(316);
        expect_stb("R8", 8);
        wait_cyc(320);
        chk(busy == 1'b0 && ref_stb == 1'b0, "R8", int'({busy, ref_stb}), 0);
        wait_cyc(321);
        expect_stb("R8", 9);
        wait_cyc(326);
        expect_stb("R8", 10);
        wait_cyc(330);
        chk(int'(ref_count) == 27, "R9", int'(ref_count), 27);
        wait_cyc(336);
        chk(ref_stb == 1'b0, "R8", int'(ref_stb), 0);
        wait_cyc(337);
        expect_stb("R8", 11);

        finish_run();
    end

endmodule